// File: doc/BRIEF.md
# Edge-Qualified Interrupt Enable Registers

This block sits on the link side of a USB transceiver's register interface. It holds two five-bit enable masks, one for upward transitions and one for downward transitions, that decide which changes of five live status lines raise an interrupt. The status lines are ID ground, session end, session valid, VBUS valid and host disconnect.

Software reaches each mask through a window of three consecutive addresses. The first address writes the mask directly, the second ORs the data into it, and the third clears the bits set in the data. All three addresses read the mask back. Reads are strobed and return their data one cycle later on a registered output.

The status lines are asynchronous. They pass through a synchronizer and are then compared with their value from the cycle before. A transition whose direction is enabled for that line produces a single-cycle interrupt pulse. It also sets a sticky request for a receive-command status update, and that request stays high until the consumer acknowledges it.

Top module: `edge_irq_regs`

## Requirements
- R1: After reset both masks read 0x1F (bits 4:0 set, bits 7:5 clear), `irq_pulse` is 0 and `rxcmd_req` is 0.
- R2: A write at 0x0D (upward mask) or 0x10 (downward mask) replaces mask bits 4:0 with write data bits 4:0.
- R3: A write at 0x0E (upward) or 0x11 (downward) sets every mask bit whose write data bit is 1 and leaves the others unchanged.
- R4: A write at 0x0F (upward) or 0x12 (downward) clears every mask bit whose write data bit is 1 and leaves the others unchanged.
- R5: A read of any of 0x0D..0x0F returns the upward mask, and a read of any of 0x10..0x12 returns the downward mask. Reads of every other address return 0, and writes to other addresses change neither mask.
- R6: Read data bits 7:5 are always 0, whatever was written to them.
- R7: Mask bit k governs `status_in[k]`, with k=0 host disconnect, 1 VBUS valid, 2 session valid, 3 session end and 4 ID ground. A transition on one line is not qualified by the mask bit of another line.
- R8: A 0-to-1 change on `status_in[k]` while upward mask bit k is 1 gives `irq_pulse` high for exactly one cycle, sampled after the third rising clock edge following the change.
- R9: A 1-to-0 change on `status_in[k]` while downward mask bit k is 1 gives the same one-cycle pulse with the same latency.
- R10: A transition whose direction is disabled for its line produces no pulse and leaves `rxcmd_req` unchanged.
- R11: `rxcmd_req` rises together with `irq_pulse`. It stays high until a cycle with `rxcmd_ack` high and no new qualified transition, and then it is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data, updated the cycle after `reg_rd` |
| status_in | input | 5 | Asynchronous status lines |
| rxcmd_ack | input | 1 | Consumer acknowledge of the update request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| rxcmd_req | output | 1 | Sticky receive-command update request |

## Verification
Random status vectors are applied against random mask contents. Some of these vectors flip several lines at once in opposite directions, which separates the upward mask from the downward mask. A directed sweep enables one line at a time and toggles every line, which exposes any swapped or misrouted bit in the mapping. Random writes across all six mask addresses and their neighbours separate write, set and clear from one another and from ignored accesses. Acknowledges are issued between events, which shows whether the request flag holds and clears correctly.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   // kind of register access decoded from an address offset
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_SET   = 2'd2,
      ACC_CLEAR = 2'd3
   } acc_kind_e;

   localparam int WINDOW = 3;

   function automatic acc_kind_e offset_to_kind(input int unsigned off);
      case (off)
         0:       return ACC_WRITE;
         1:       return ACC_SET;
         2:       return ACC_CLEAR;
         default: return ACC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/eir_sync.sv
module eir_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/eir_enable_reg.sv
module eir_enable_reg
   import edge_irq_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int NUM_SRC   = 5,
   parameter int BASE      = 'h0D,
   parameter logic [NUM_SRC-1:0] RESET_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr,
   output logic              hit,
   output logic [NUM_SRC-1:0] mask
);

   localparam int LAST = BASE + WINDOW - 1;

   logic [31:0]        addr_ext;
   int unsigned        off;
   acc_kind_e          kind;
   logic [NUM_SRC-1:0] mask_nxt;

   always_comb begin
      addr_ext = 32'(addr);
      hit      = (addr_ext >= 32'(BASE)) && (addr_ext <= 32'(LAST));
      off      = hit ? (addr_ext - 32'(BASE)) : 32'd0;
      kind     = (hit && wr) ? offset_to_kind(off) : ACC_NONE;
   end

   // per-bit next value; reserved write bits above NUM_SRC are never looked at
   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      always_comb begin
         case (kind)
            ACC_WRITE: mask_nxt[b] = wdata[b];
            ACC_SET:   mask_nxt[b] = mask[b] | wdata[b];
            ACC_CLEAR: mask_nxt[b] = mask[b] & ~wdata[b];
            default:   mask_nxt[b] = mask[b];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= RESET_VAL;
      else        mask <= mask_nxt;
   end

endmodule

// File: rtl/eir_edge_irq.sv
module eir_edge_irq #(
   parameter int NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] cur,
   input  logic [NUM_SRC-1:0] rise_en,
   input  logic [NUM_SRC-1:0] fall_en,
   input  logic               ack,
   output logic               irq,
   output logic               req
);

   logic [NUM_SRC-1:0] prev;
   logic [NUM_SRC-1:0] qual;
   logic               any_qual;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
      assign qual[i] = (cur[i] & ~prev[i] & rise_en[i]) |
                       (~cur[i] & prev[i] & fall_en[i]);
   end

   assign any_qual = |qual;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
         irq  <= 1'b0;
         req  <= 1'b0;
      end else begin
         prev <= cur;
         irq  <= any_qual;
         if (any_qual)  req <= 1'b1;
         else if (ack)  req <= 1'b0;
      end
   end

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int NUM_SRC     = 5,
   parameter int SYNC_STAGES = 2,
   parameter int RISE_BASE   = 'h0D,
   parameter int FALL_BASE   = 'h10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_wr,
   input  logic               reg_rd,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] status_in,
   input  logic               rxcmd_ack,
   output logic               irq_pulse,
   output logic               rxcmd_req
);

   localparam int PAD_W = DATA_W - NUM_SRC;

   if (NUM_SRC > DATA_W) begin : g_chk_width
      $error("NUM_SRC must not exceed DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((RISE_BASE + 3 > FALL_BASE) && (FALL_BASE + 3 > RISE_BASE)) begin : g_chk_overlap
      $error("register windows overlap");
   end
   if ((RISE_BASE + 3 > (1 << ADDR_W)) || (FALL_BASE + 3 > (1 << ADDR_W))) begin : g_chk_range
      $error("register window beyond address space");
   end

   logic [NUM_SRC-1:0] st_sync;
   logic [NUM_SRC-1:0] rise_mask, fall_mask;
   logic               rise_hit, fall_hit;
   logic [DATA_W-1:0]  rd_val;

   eir_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(status_in), .q_sync(st_sync)
   );

   eir_enable_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .BASE(RISE_BASE)
   ) u_rise (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
      .wr(reg_wr), .hit(rise_hit), .mask(rise_mask)
   );

   eir_enable_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .BASE(FALL_BASE)
   ) u_fall (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
      .wr(reg_wr), .hit(fall_hit), .mask(fall_mask)
   );

   eir_edge_irq #(.NUM_SRC(NUM_SRC)) u_edge (
      .clk(clk), .rst_n(rst_n), .cur(st_sync), .rise_en(rise_mask),
      .fall_en(fall_mask), .ack(rxcmd_ack), .irq(irq_pulse), .req(rxcmd_req)
   );

   if (PAD_W > 0) begin : g_pad
      always_comb begin
         rd_val = '0;
         if (rise_hit)      rd_val = {{PAD_W{1'b0}}, rise_mask};
         else if (fall_hit) rd_val = {{PAD_W{1'b0}}, fall_mask};
      end
   end else begin : g_nopad
      always_comb begin
         rd_val = '0;
         if (rise_hit)      rd_val = rise_mask;
         else if (fall_hit) rd_val = fall_mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_val;
   end

endmodule

// File: rtl/edge_irq_regs_chk.sv
module edge_irq_regs_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int NUM_SRC   = 5,
   parameter int RISE_BASE = 'h0D,
   parameter int FALL_BASE = 'h10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              rxcmd_ack,
   input logic              irq_pulse,
   input logic              rxcmd_req
);

   logic [31:0] a_ext;
   logic        in_win;
   assign a_ext  = 32'(reg_addr);
   assign in_win = ((a_ext >= 32'(RISE_BASE)) && (a_ext < 32'(RISE_BASE + 3))) ||
                   ((a_ext >= 32'(FALL_BASE)) && (a_ext < 32'(FALL_BASE + 3)));

   // R5
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !in_win) |=> (reg_rdata == '0));

   // R6
   reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_rdata >> NUM_SRC) == '0));

   // R11
   pulse_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> rxcmd_req);

   // R11
   req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxcmd_req && !rxcmd_ack) |=> rxcmd_req);

   // R11
   req_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxcmd_req) |-> irq_pulse);

   // R11
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxcmd_req && rxcmd_ack) |=> (rxcmd_req == irq_pulse));

endmodule

bind edge_irq_regs edge_irq_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
   .RISE_BASE(RISE_BASE), .FALL_BASE(FALL_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
   .reg_rdata(reg_rdata), .rxcmd_ack(rxcmd_ack), .irq_pulse(irq_pulse),
   .rxcmd_req(rxcmd_req)
);

// File: tb/edge_irq_regs_bench.sv
module edge_irq_regs_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic [4:0] status_in = '0;
   logic       rxcmd_ack = 1'b0;
   logic       irq_pulse;
   logic       rxcmd_req;

   int checks = 0;
   int errors = 0;

   logic [4:0] rise_m = 5'h1F;
   logic [4:0] fall_m = 5'h1F;
   logic [4:0] stat_m = 5'h00;
   logic       req_m  = 1'b0;

   always #5 clk = ~clk;

   edge_irq_regs u_edge_irq_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .status_in(status_in), .rxcmd_ack(rxcmd_ack), .irq_pulse(irq_pulse),
      .rxcmd_req(rxcmd_req)
   );

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [4:0] apply_acc(input logic [4:0] old, input int off,
                                            input logic [7:0] d);
      case (off)
         0: return d[4:0];
         1: return old | d[4:0];
         2: return old & ~d[4:0];
         default: return old;
      endcase
   endfunction

   function automatic logic [7:0] expect_read(input logic [7:0] a);
      if (a >= 8'h0D && a <= 8'h0F) return {3'b000, rise_m};
      if (a >= 8'h10 && a <= 8'h12) return {3'b000, fall_m};
      return 8'h00;
   endfunction

   function automatic logic event_of(input logic [4:0] old_s, input logic [4:0] new_s);
      return |((new_s & ~old_s & rise_m) | (~new_s & old_s & fall_m));
   endfunction

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
      if (a >= 8'h0D && a <= 8'h0F) rise_m = apply_acc(rise_m, int'(a) - 'h0D, d);
      if (a >= 8'h10 && a <= 8'h12) fall_m = apply_acc(fall_m, int'(a) - 'h10, d);
   endtask

   task automatic do_read_check(input logic [7:0] a, input string tag);
      logic [7:0] e;
      e = expect_read(a);
      reg_addr = a; reg_rd = 1'b1;
      tick();
      reg_rd = 1'b0;
      check(reg_rdata == e, tag, reg_rdata, e);
   endtask

   task automatic read_all(input string tag);
      for (int a = 'h0B; a <= 'h14; a++) do_read_check(8'(a), tag);
   endtask

   // apply a status vector and check pulse timing and request flag
   task automatic status_step(input logic [4:0] nv, input string tag);
      logic ev;
      ev = event_of(stat_m, nv);
      status_in = nv;
      stat_m = nv;
      tick();
      check(irq_pulse == 1'b0, {tag, " early pulse"}, irq_pulse, 0);
      tick();
      check(irq_pulse == 1'b0, {tag, " early pulse"}, irq_pulse, 0);
      tick();
      check(irq_pulse == ev, tag, irq_pulse, ev);
      req_m = req_m | ev;
      check(rxcmd_req == req_m, {tag, " R11 req"}, rxcmd_req, req_m);
      tick();
      check(irq_pulse == 1'b0, {tag, " pulse width"}, irq_pulse, 0);
   endtask

   task automatic do_ack();
      rxcmd_ack = 1'b1;
      tick();
      rxcmd_ack = 1'b0;
      req_m = 1'b0;
      check(rxcmd_req == 1'b0, "R11 ack clears", rxcmd_req, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      check(irq_pulse == 1'b0, "R1 irq", irq_pulse, 0);
      check(rxcmd_req == 1'b0, "R1 req", rxcmd_req, 0);
      do_read_check(8'h0D, "R1 rise reset");
      do_read_check(8'h10, "R1 fall reset");

      // R2 R3 R4 directed
      do_write(8'h0D, 8'hEA); do_read_check(8'h0F, "R2 rise write");
      do_write(8'h0E, 8'h05); do_read_check(8'h0D, "R3 rise set");
      do_write(8'h0F, 8'h0C); do_read_check(8'h0E, "R4 rise clear");
      do_write(8'h10, 8'h13); do_read_check(8'h12, "R2 fall write");
      do_write(8'h11, 8'hE8); do_read_check(8'h10, "R3 fall set");
      do_write(8'h12, 8'h11); do_read_check(8'h11, "R4 fall clear");
      // R6 reserved bits after all-ones writes
      do_write(8'h0D, 8'hFF); do_read_check(8'h0D, "R6 reserved");

      // R5 out-of-window writes leave masks alone
      do_write(8'h0C, 8'h00); do_write(8'h13, 8'h00);
      do_write(8'h00, 8'h00); do_write(8'hFF, 8'h00);
      read_all("R5 window");
      do_read_check(8'h00, "R5 unmapped");
      do_read_check(8'hFF, "R5 unmapped");

      // random register traffic
      for (int i = 0; i < 80; i++) begin
         logic [7:0] a;
         a = 8'(8'h0B + ($urandom % 10));
         do_write(a, 8'($urandom));
         do_read_check(8'(8'h0B + ($urandom % 10)), "R2 R3 R4 R5 random");
      end

      // R7 one line enabled at a time, every line toggled both ways
      for (int k = 0; k < 5; k++) begin
         do_write(8'h0D, 8'(1 << k));
         do_write(8'h10, 8'(1 << k));
         for (int j = 0; j < 5; j++) begin
            status_step(stat_m ^ 5'(1 << j), (j == k) ? "R7 R8 R9 own line" : "R7 R10 other line");
            status_step(stat_m ^ 5'(1 << j), (j == k) ? "R7 R8 R9 own line" : "R7 R10 other line");
            if (req_m) do_ack();
         end
      end

      // R8 R9 directions separated
      do_write(8'h0D, 8'h1F); do_write(8'h10, 8'h00);
      status_step(5'h00, "R10 settle");
      if (req_m) do_ack();
      status_step(5'h15, "R8 rise only");
      status_step(5'h00, "R10 fall disabled");
      do_ack();
      do_write(8'h0D, 8'h00); do_write(8'h10, 8'h1F);
      status_step(5'h0A, "R10 rise disabled");
      status_step(5'h00, "R9 fall only");
      // R11 request held across a second event without ack
      status_step(5'h1F, "R11 no event");
      status_step(5'h00, "R11 second event");
      do_ack();

      // random status with random masks
      for (int i = 0; i < 150; i++) begin
         if (($urandom % 4) == 0) do_write(8'(8'h0D + ($urandom % 6)), 8'($urandom));
         status_step(5'($urandom), "R8 R9 R10 random");
         if (($urandom % 3) == 0 && req_m) do_ack();
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule